// File: doc/BRIEF.md
# Fractional-Ratio Square-Wave Divider

This block produces a slow square wave from a fast reference clock when the reference-to-output ratio is not a whole number. It is built with the reference frequency, the output frequency and a group size as parameters. From these it derives a base period and the number of periods in each group that must run one cycle longer. It then steps through the group one period at a time. The long periods come first and the base-length periods follow. The average output period is therefore exact, and phase error never accumulates beyond one group.

With the default settings, a 50 MHz reference and a 300 Hz output, the ideal period is about 166666.67 cycles. A fixed count of 166666 would run about 4 ppm fast. The block instead uses a group of three periods: two of 166667 cycles and one of 166666 cycles. Every group therefore spans exactly 500000 reference cycles.

The block runs entirely on the reference clock and uses integer arithmetic only. Besides the wave, it emits a one-cycle tick at the start of each output period, which downstream logic can use as a clock enable. The parameters must be chosen so that the group holds a whole number of reference cycles, that is, (REF_HZ mod OUT_HZ) times GROUP_LEN must be a multiple of OUT_HZ.

Top module: `frac_clk_div`

## Requirements
- R1: An output period in a long slot lasts BASE+1 reference cycles, and one in a base slot lasts BASE cycles. BASE is REF_HZ/OUT_HZ rounded down.
- R2: Each group of GROUP_LEN periods spans exactly REF_HZ*GROUP_LEN/OUT_HZ reference cycles, so each group boundary falls on a multiple of that count after reset. The default is 500000.
- R3: Slot selection works as follows:
  - The slot index starts at 0 and advances by one only when an output period completes.
  - After slot GROUP_LEN-1 it wraps to 0.
  - Slots below NUM_LONG are long, where NUM_LONG = (REF_HZ mod OUT_HZ)*GROUP_LEN/OUT_HZ; all other slots are base slots.
- R4: tickOut is 1 on the first reference cycle of every output period and 0 on every other cycle.
- R5: waveOut is 1 for the first floor(L/2) cycles of a period of length L and 0 for the remaining cycles.
- R6: While rst (synchronous, active high) is 1, waveOut and tickOut are 0. The cycle after rst is released is the first cycle of a slot-0 period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| waveOut | output | 1 | Divided square wave |
| tickOut | output | 1 | One-cycle pulse on the first cycle of each output period |

## Verification
On every cycle, the embedded assertions check the following:
- the period counter stays below the current period length;
- the tick follows each period end and never lasts two cycles;
- the wave falls exactly at the half-period point;
- the slot index holds between period ends and wraps after the last slot.

The exact order of long and base periods and the group total can only be shown by the bench. It sweeps several whole groups with a small ratio, compares every cycle against a position computed from the cycle count, and applies a reset in the middle of a period to confirm the restart in slot 0.

// File: rtl/frac_clk_div_pkg.sv
package frac_clk_div_pkg;
  // Strobes from the slot sequencer to the period datapath
  typedef struct packed {
    logic clear;    // hold counter at zero, outputs low
    logic useLong;  // current period is BASE+1 cycles
  } divStrobes_t;
endpackage

// File: rtl/frac_clk_div_ctrl.sv
module frac_clk_div_ctrl
  import frac_clk_div_pkg::*;
#(
  parameter int GROUP_LEN = 3,
  parameter int NUM_LONG  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        periodEnd,
  output divStrobes_t strobes
);
  localparam int SLOT_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_LEN - 1);
  localparam logic [SLOT_W:0]   LONG_LIM  = (SLOT_W+1)'(NUM_LONG);

  logic [SLOT_W-1:0] slotIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      slotIdx <= '0;
    end else if (periodEnd) begin
      if (slotIdx == LAST_SLOT) slotIdx <= '0;
      else                      slotIdx <= slotIdx + 1'b1;
    end
  end

  always_comb begin
    strobes.clear   = rst;
    strobes.useLong = ({1'b0, slotIdx} < LONG_LIM);
  end

  // R3
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (periodEnd && slotIdx == LAST_SLOT) |=> (slotIdx == '0));

  // R3
  slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !periodEnd |=> $stable(slotIdx));

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    slotIdx <= LAST_SLOT);
endmodule

// File: rtl/frac_clk_div_datapath.sv
module frac_clk_div_datapath
  import frac_clk_div_pkg::*;
#(
  parameter int BASE  = 166666,
  parameter int CNT_W = 18
) (
  input  logic        clk,
  input  divStrobes_t strobes,
  output logic        periodEnd,
  output logic        waveOut,
  output logic        tickOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curLen;
  logic [CNT_W-1:0] halfLen;

  always_comb begin
    curLen    = CNT_W'(BASE) + {{(CNT_W-1){1'b0}}, strobes.useLong};
    halfLen   = curLen >> 1;
    periodEnd = !strobes.clear && (cnt == curLen - CNT_W'(1));
    waveOut   = !strobes.clear && (cnt < halfLen);
    tickOut   = !strobes.clear && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (strobes.clear || periodEnd) cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    cnt < curLen);

  // R4
  tick_follow_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    periodEnd |=> tickOut);

  // R4
  tick_single_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    tickOut |=> !tickOut);

  // R5
  wave_fall_chk: assert property (@(posedge clk) disable iff (strobes.clear)
    $fell(waveOut) |-> (cnt == halfLen));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    strobes.clear |=> (cnt == '0));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
  import frac_clk_div_pkg::*;
#(
  parameter int REF_HZ    = 50_000_000,
  parameter int OUT_HZ    = 300,
  parameter int GROUP_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  output logic waveOut,
  output logic tickOut
);
  localparam int BASE     = REF_HZ / OUT_HZ;
  localparam int NUM_LONG = ((REF_HZ % OUT_HZ) * GROUP_LEN) / OUT_HZ;
  localparam int CNT_W    = $clog2(BASE + 2);

  divStrobes_t strobes;
  logic        periodEnd;

  frac_clk_div_ctrl #(
    .GROUP_LEN(GROUP_LEN),
    .NUM_LONG (NUM_LONG)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .periodEnd(periodEnd),
    .strobes  (strobes)
  );

  frac_clk_div_datapath #(
    .BASE (BASE),
    .CNT_W(CNT_W)
  ) u_datapath (
    .clk      (clk),
    .strobes  (strobes),
    .periodEnd(periodEnd),
    .waveOut  (waveOut),
    .tickOut  (tickOut)
  );

  // R6
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (!waveOut && !tickOut));

  // R5
  tick_high_chk: assert property (@(posedge clk) disable iff (rst)
    tickOut |-> waveOut);
endmodule

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
  // Small ratio: 20/3 -> periods 7,7,6, group of 20 cycles
  localparam int REF   = 20;
  localparam int OUTF  = 3;
  localparam int GRP   = 3;
  localparam int BASE  = 6;
  localparam int NLONG = 2;
  localparam int TOTAL = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic waveOut, tickOut;
  int checkCount = 0;
  int failCount  = 0;

  always #2.5 clk = ~clk;

  frac_clk_div #(.REF_HZ(REF), .OUT_HZ(OUTF), .GROUP_LEN(GRP)) u_frac_clk_div (
    .clk(clk), .rst(rst), .waveOut(waveOut), .tickOut(tickOut)
  );

  function automatic int slotLen(int s);
    return BASE + ((s < NLONG) ? 1 : 0);
  endfunction

  task automatic expectBit(logic act, logic exp, string tag, int k);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", tag, k, act, exp);
    end
  endtask

  task automatic expectInt(int act, int exp, string tag, int k);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, k, act, exp);
    end
  endtask

  // Called right after a release of rst at a negative edge
  task automatic runPhase(int n);
    int lastTick = -1;
    int periodIdx = 0;
    for (int k = 0; k < n; k++) begin
      int pos = k % TOTAL;
      int s = 0;
      int off = pos;
      #1;
      while (off >= slotLen(s)) begin
        off -= slotLen(s);
        s++;
      end
      expectBit(tickOut, (off == 0), "R4 tick", k);
      expectBit(waveOut, (off < slotLen(s) / 2), "R5 wave", k);
      if (pos == 0) expectBit(tickOut, 1'b1, "R2 group boundary", k);
      if (k == 0)   expectBit(tickOut, 1'b1, "R6 restart", k);
      if (tickOut === 1'b1) begin
        if (lastTick >= 0)
          expectInt(k - lastTick, slotLen((periodIdx - 1) % GRP), "R1 R3 period length", k);
        lastTick = k;
        periodIdx++;
      end
      @(negedge clk);
    end
  endtask

  task automatic holdReset(int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      #1;
      expectBit(waveOut, 1'b0, "R6 wave in reset", i);
      expectBit(tickOut, 1'b0, "R6 tick in reset", i);
      @(negedge clk);
    end
    rst = 1'b0;
  endtask

  initial begin
    #20_000;
    failCount++;
    checkCount++;
    $display("FAIL R4 watchdog expired actual running expected done");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    @(negedge clk);
    holdReset(3);
    runPhase(130);   // ends mid-period (130 mod 20 = 10)
    holdReset(3);
    runPhase(70);
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule